// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a 16-bit parallel NOR flash. It turns one high-level operation into the exact run of bus cycles the flash's command state machine expects. The supported operations are:

- identifier read
- query-table read
- return to read array
- single-word program
- multi-word buffered program
- block erase
- chip erase

Each operation expands into a fixed or counted script. The script is the unlock pair, the command code, then any data or read cycles. The block emits it one access per clock on a simple strobe bus.

The host presents a request with `req_valid` and the operation fields. The block answers with `req_ack` in the same cycle whenever it is idle, and the request is taken at that clock edge. For buffered programming, the data words come in over a valid/ready stream:

- `wdat_ready` is high only while the block is loading words.
- A word is consumed on any cycle where `wdat_valid` and `wdat_ready` are both high. Each consumed word becomes one bus write in that same cycle.
- If the source holds `wdat_valid` low, no bus cycle is emitted and the sequence simply stretches.
- The source may raise `wdat_valid` early. It must then hold the word steady until it sees `wdat_ready`.

Read cycles on the flash bus are captured and handed back on `rd_data` with a one-cycle `rd_valid` pulse.

Top module: `nor_cmd_seq`

## Requirements
- R1: Identifier read, single program, buffer program and both erases each start with two writes: 0xAA to word address 0x555, then 0x55 to word address 0x2AA.
- R2: Identifier read (opcode 0) writes 0x90 to 0x555 after the unlock pair. It then reads word addresses 0x000, 0x001, 0x00E and 0x00F, in that order. Each read result appears on `rd_data` with `rd_valid` high in the cycle after its read strobe.
- R3: Query read (opcode 1) is one write of 0x98 to 0x055 with no unlock cycles. It is followed by reads of 0x010, 0x011, 0x012 and 0x013.
- R4: Return to read (opcode 2) is exactly one write of 0xF0 to address 0x000.
- R5: Single program (opcode 3) writes the unlock pair, then 0xA0 to 0x555, then `req_data` to `req_addr`.
- R6: Block erase (opcode 5) writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, and finally 0x30 to `req_addr`.
- R7: Chip erase (opcode 6) writes the same five-cycle prefix as R6, and finishes with 0x10 to 0x555.
- R8: Buffer program (opcode 4) with count n writes, in order:
  - the unlock pair;
  - 0x25 to `req_addr`;
  - n-1 to `req_addr`;
  - stream word i to `req_addr`+i, for i = 0 to n-1;
  - 0x29 to `req_addr`+n-1.
- R9: `wdat_ready` is high only during the word-loading phase. A cycle with `wdat_valid` low during that phase emits no bus cycle. Stream activity while idle has no effect.
- R10: `req_ack` equals `req_valid` while idle and is low while busy. `busy` rises in the cycle after acceptance and stays high through the last bus cycle. The first bus cycle is in the cycle after acceptance.
- R11: These requests are accepted and then rejected: a buffer program with count 0, a buffer program with count above `BUF_MAX` (default 16), and opcode 7. A rejected request gives a one-cycle `err` pulse in the cycle after acceptance. `busy` stays low and no bus cycle is emitted.
- R12: Each bus access lasts one clock. `bus_we` and `bus_re` are never high together, and cycles within a fixed script are back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ack | output | 1 | Request taken at this clock edge |
| req_op | input | 3 | Operation code (0 id, 1 query, 2 reset, 3 program, 4 buffer, 5 block erase, 6 chip erase) |
| req_addr | input | ADDR_W | Target or start word address |
| req_data | input | DATA_W | Word for single program |
| req_count | input | CNT_W | Word count for buffer program |
| wdat_valid | input | 1 | Buffer word valid |
| wdat_ready | output | 1 | Block accepts a buffer word |
| wdat_data | input | DATA_W | Buffer word |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | One-cycle reject pulse |
| bus_we | output | 1 | Flash write strobe |
| bus_re | output | 1 | Flash read strobe |
| bus_addr | output | ADDR_W | Flash word address |
| bus_wdata | output | DATA_W | Flash write data |
| bus_rdata | input | DATA_W | Flash read data, valid while bus_re is high |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read result |

## Verification
The assertions assume the following about the environment:
- The flash returns `bus_rdata` combinationally during a read strobe.
- The stream source keeps a word steady while `wdat_valid` is high and `wdat_ready` is low.
- A host request is only treated as taken when it sees `req_ack`.

The bench drives inputs one nanosecond after the rising edge and holds a request until `req_ack` is sampled. It keeps each buffer word on the stream until `wdat_ready` is seen. It also deliberately raises `req_valid` during a busy erase and `wdat_valid` while idle, to confirm that both are refused with no bus effect.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ_ID    = 3'd0,
    OP_QUERY      = 3'd1,
    OP_RESET      = 3'd2,
    OP_PROG       = 3'd3,
    OP_BUFPROG    = 3'd4,
    OP_BLK_ERASE  = 3'd5,
    OP_CHIP_ERASE = 3'd6,
    OP_NONE       = 3'd7
  } nor_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCRIPT,
    ST_LOAD,
    ST_CONFIRM
  } seq_state_e;

  localparam int STEP_W = 3;

  // command word addresses
  localparam logic [11:0] A_KEY1  = 12'h555;
  localparam logic [11:0] A_KEY2  = 12'h2AA;
  localparam logic [11:0] A_QUERY = 12'h055;
  localparam logic [11:0] A_BASE  = 12'h000;

  // read-back addresses for identifier and query tables
  localparam logic [11:0] A_ID_MFR  = 12'h000;
  localparam logic [11:0] A_ID_DEV1 = 12'h001;
  localparam logic [11:0] A_ID_DEV2 = 12'h00E;
  localparam logic [11:0] A_ID_DEV3 = 12'h00F;
  localparam logic [11:0] A_QTAB    = 12'h010;

  // command codes
  localparam logic [7:0] C_KEY1      = 8'hAA;
  localparam logic [7:0] C_KEY2      = 8'h55;
  localparam logic [7:0] C_AUTOSEL   = 8'h90;
  localparam logic [7:0] C_WORDPROG  = 8'hA0;
  localparam logic [7:0] C_ERASE_SET = 8'h80;
  localparam logic [7:0] C_ERASE_BLK = 8'h30;
  localparam logic [7:0] C_ERASE_ALL = 8'h10;
  localparam logic [7:0] C_QUERY     = 8'h98;
  localparam logic [7:0] C_READ_ARR  = 8'hF0;
  localparam logic [7:0] C_BUF_LOAD  = 8'h25;
  localparam logic [7:0] C_BUF_GO    = 8'h29;

endpackage

// File: rtl/nor_seq_script.sv
module nor_seq_script
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  nor_op_e             op,
  input  logic [STEP_W-1:0]   idx,
  input  logic [ADDR_W-1:0]   tgt_addr,
  input  logic [DATA_W-1:0]   wr_word,
  input  logic [CNT_W-1:0]    cnt,
  output logic                s_rd,
  output logic [ADDR_W-1:0]   s_addr,
  output logic [DATA_W-1:0]   s_data,
  output logic                s_last
);

  logic [11:0] a12;
  logic [7:0]  d8;
  logic        use_tgt;
  logic        use_word;
  logic        use_cnt;

  always_comb begin
    a12      = A_BASE;
    d8       = 8'h00;
    s_rd     = 1'b0;
    s_last   = 1'b0;
    use_tgt  = 1'b0;
    use_word = 1'b0;
    use_cnt  = 1'b0;
    case (op)
      OP_READ_ID: begin
        case (idx)
          3'd0: begin a12 = A_KEY1; d8 = C_KEY1; end
          3'd1: begin a12 = A_KEY2; d8 = C_KEY2; end
          3'd2: begin a12 = A_KEY1; d8 = C_AUTOSEL; end
          3'd3: begin a12 = A_ID_MFR;  s_rd = 1'b1; end
          3'd4: begin a12 = A_ID_DEV1; s_rd = 1'b1; end
          3'd5: begin a12 = A_ID_DEV2; s_rd = 1'b1; end
          default: begin a12 = A_ID_DEV3; s_rd = 1'b1; s_last = 1'b1; end
        endcase
      end
      OP_QUERY: begin
        case (idx)
          3'd0: begin a12 = A_QUERY; d8 = C_QUERY; end
          3'd1: begin a12 = A_QTAB;          s_rd = 1'b1; end
          3'd2: begin a12 = A_QTAB + 12'd1;  s_rd = 1'b1; end
          3'd3: begin a12 = A_QTAB + 12'd2;  s_rd = 1'b1; end
          default: begin a12 = A_QTAB + 12'd3; s_rd = 1'b1; s_last = 1'b1; end
        endcase
      end
      OP_RESET: begin
        a12    = A_BASE;
        d8     = C_READ_ARR;
        s_last = 1'b1;
      end
      OP_PROG: begin
        case (idx)
          3'd0: begin a12 = A_KEY1; d8 = C_KEY1; end
          3'd1: begin a12 = A_KEY2; d8 = C_KEY2; end
          3'd2: begin a12 = A_KEY1; d8 = C_WORDPROG; end
          default: begin use_tgt = 1'b1; use_word = 1'b1; s_last = 1'b1; end
        endcase
      end
      OP_BUFPROG: begin
        case (idx)
          3'd0: begin a12 = A_KEY1; d8 = C_KEY1; end
          3'd1: begin a12 = A_KEY2; d8 = C_KEY2; end
          3'd2: begin use_tgt = 1'b1; d8 = C_BUF_LOAD; end
          default: begin use_tgt = 1'b1; use_cnt = 1'b1; s_last = 1'b1; end
        endcase
      end
      OP_BLK_ERASE, OP_CHIP_ERASE: begin
        case (idx)
          3'd0: begin a12 = A_KEY1; d8 = C_KEY1; end
          3'd1: begin a12 = A_KEY2; d8 = C_KEY2; end
          3'd2: begin a12 = A_KEY1; d8 = C_ERASE_SET; end
          3'd3: begin a12 = A_KEY1; d8 = C_KEY1; end
          3'd4: begin a12 = A_KEY2; d8 = C_KEY2; end
          default: begin
            s_last = 1'b1;
            if (op == OP_BLK_ERASE) begin
              use_tgt = 1'b1;
              d8      = C_ERASE_BLK;
            end else begin
              a12 = A_KEY1;
              d8  = C_ERASE_ALL;
            end
          end
        endcase
      end
      default: begin
        s_last = 1'b1;
      end
    endcase
  end

  assign s_addr = use_tgt ? tgt_addr : ADDR_W'(a12);
  assign s_data = use_word ? wr_word :
                  use_cnt  ? DATA_W'(cnt - CNT_W'(1)) : DATA_W'(d8);

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int BUF_MAX = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ack,
  input  logic [2:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [CNT_W-1:0]    req_count,
  input  logic                wdat_valid,
  output logic                wdat_ready,
  input  logic [DATA_W-1:0]   wdat_data,
  output logic                busy,
  output logic                err,
  // script decoder link
  output nor_op_e             op_q,
  output logic [STEP_W-1:0]   step_q,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [DATA_W-1:0]   data_q,
  output logic [CNT_W-1:0]    cnt_q,
  input  logic                s_rd,
  input  logic [ADDR_W-1:0]   s_addr,
  input  logic [DATA_W-1:0]   s_data,
  input  logic                s_last,
  // flash strobe bus
  output logic                bus_we,
  output logic                bus_re,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata
);

  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(BUF_MAX);

  seq_state_e        state;
  logic [CNT_W-1:0]  load_idx;
  logic [CNT_W-1:0]  last_idx;
  logic              err_q;
  nor_op_e           op_in;
  logic              req_bad;

  assign op_in    = nor_op_e'(req_op);
  assign req_bad  = (op_in == OP_NONE) ||
                    ((op_in == OP_BUFPROG) &&
                     ((req_count == '0) || (req_count > CNT_LIMIT)));
  assign req_ack    = (state == ST_IDLE) && req_valid;
  assign busy       = (state != ST_IDLE);
  assign err        = err_q;
  assign wdat_ready = (state == ST_LOAD);
  assign last_idx   = cnt_q - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_NONE;
      step_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      cnt_q    <= '0;
      load_idx <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_bad) begin
              err_q <= 1'b1;
            end else begin
              op_q   <= op_in;
              addr_q <= req_addr;
              data_q <= req_data;
              cnt_q  <= req_count;
              step_q <= '0;
              state  <= ST_SCRIPT;
            end
          end
        end
        ST_SCRIPT: begin
          if (s_last) begin
            load_idx <= '0;
            state    <= (op_q == OP_BUFPROG) ? ST_LOAD : ST_IDLE;
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
        ST_LOAD: begin
          if (wdat_valid) begin
            if (load_idx == last_idx) state <= ST_CONFIRM;
            else load_idx <= load_idx + CNT_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // bus source select: script step, streamed word, or closing confirm
  always_comb begin
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      ST_SCRIPT: begin
        bus_we    = !s_rd;
        bus_re    = s_rd;
        bus_addr  = s_addr;
        bus_wdata = s_data;
      end
      ST_LOAD: begin
        bus_we    = wdat_valid;
        bus_addr  = addr_q + ADDR_W'(load_idx);
        bus_wdata = wdat_data;
      end
      ST_CONFIRM: begin
        bus_we    = 1'b1;
        bus_addr  = addr_q + ADDR_W'(last_idx);
        bus_wdata = DATA_W'(C_BUF_GO);
      end
      default: ;
    endcase
  end

  p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ack);

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  p_reject_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !bus_we && !bus_re));

  p_unlock_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCRIPT && step_q == '0 &&
     op_q inside {OP_READ_ID, OP_PROG, OP_BUFPROG, OP_BLK_ERASE, OP_CHIP_ERASE})
    |-> (bus_we && bus_wdata == DATA_W'(C_KEY1) && bus_addr == ADDR_W'(A_KEY1)));

  p_ready_in_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_ready |-> busy);

  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat_ready && !wdat_valid) |-> !bus_we);

  p_confirm_follows_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONFIRM) |-> $past(wdat_ready && wdat_valid));

endmodule

// File: rtl/nor_seq_rdcap.sv
module nor_seq_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_re;
      if (bus_re) rd_data <= bus_rdata;
    end
  end

  p_result_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_re));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int BUF_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ack,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wdat_valid,
  output logic              wdat_ready,
  input  logic [DATA_W-1:0] wdat_data,
  output logic              busy,
  output logic              err,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  nor_op_e           op_q;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              s_rd;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic              s_last;

  nor_seq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BUF_MAX(BUF_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ack(req_ack), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_count(req_count),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .busy(busy), .err(err),
    .op_q(op_q), .step_q(step_q), .addr_q(addr_q), .data_q(data_q), .cnt_q(cnt_q),
    .s_rd(s_rd), .s_addr(s_addr), .s_data(s_data), .s_last(s_last),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  nor_seq_script #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_script (
    .op(op_q), .idx(step_q), .tgt_addr(addr_q), .wr_word(data_q), .cnt(cnt_q),
    .s_rd(s_rd), .s_addr(s_addr), .s_data(s_data), .s_last(s_last)
  );

  nor_seq_rdcap #(
    .DATA_W(DATA_W)
  ) u_rdcap (
    .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: tb/test_nor_cmd_seq.sv
`timescale 1ns/1ps
module test_nor_cmd_seq;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int BMAX = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ack;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] req_count = '0;
  logic          wdat_valid = 1'b0;
  logic          wdat_ready;
  logic [DW-1:0] wdat_data = '0;
  logic          busy, err;
  logic          bus_we, bus_re;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;

  // expected bus cycles and read results
  bit            q_rd[$];
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_dat[$];
  string         q_tag[$];
  logic [DW-1:0] r_dat[$];
  string         r_tag[$];

  always #2.5 clk = ~clk;

  // flash read model
  function automatic logic [DW-1:0] flash_word(logic [AW-1:0] a);
    return 16'h5A00 ^ a[15:0];
  endfunction
  assign bus_rdata = bus_re ? flash_word(bus_addr) : '0;

  nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .BUF_MAX(BMAX)) i_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ack(req_ack), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_count(req_count),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .busy(busy), .err(err),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    q_rd.push_back(1'b0); q_addr.push_back(a); q_dat.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic exp_rd(logic [AW-1:0] a, string tag);
    q_rd.push_back(1'b1); q_addr.push_back(a); q_dat.push_back('0); q_tag.push_back(tag);
    r_dat.push_back(flash_word(a)); r_tag.push_back(tag);
  endtask

  task automatic exp_unlock(string tag);
    exp_wr(24'h555, 16'h00AA, tag);
    exp_wr(24'h2AA, 16'h0055, tag);
  endtask

  // monitor: compare every bus cycle and read result against the queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_we || bus_re) begin
        chk(!(bus_we && bus_re), "R12", "both strobes", {bus_we, bus_re}, 2'b00);
        chk(busy, "R10", "busy during cycle", busy, 1);
        if (q_rd.size() == 0) begin
          chk(1'b0, "R12", "unexpected bus cycle addr", bus_addr, 0);
        end else begin
          automatic bit            e_rd = q_rd.pop_front();
          automatic logic [AW-1:0] e_a  = q_addr.pop_front();
          automatic logic [DW-1:0] e_d  = q_dat.pop_front();
          automatic string         e_t  = q_tag.pop_front();
          chk(bus_re == e_rd, e_t, "strobe kind", bus_re, e_rd);
          chk(bus_addr == e_a, e_t, "bus addr", bus_addr, e_a);
          if (!e_rd) chk(bus_wdata == e_d, e_t, "bus data", bus_wdata, e_d);
        end
      end
      if (rd_valid) begin
        if (r_dat.size() == 0) begin
          chk(1'b0, "R2", "unexpected rd_valid", rd_data, 0);
        end else begin
          automatic logic [DW-1:0] e_r = r_dat.pop_front();
          automatic string         e_t = r_tag.pop_front();
          chk(rd_data == e_r, e_t, "read result", rd_data, e_r);
        end
      end
    end
  end

  task automatic issue(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d, logic [CW-1:0] n);
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_count = n;
    do @(negedge clk); while (!req_ack);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || q_rd.size() != 0 || r_dat.size() != 0);
    @(negedge clk);
    chk(!busy, "R10", "busy after end", busy, 0);
  endtask

  task automatic feed(int n, bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall) begin
        wdat_valid = 1'b0;
        repeat (i % 3) begin @(posedge clk); #1; end
      end
      wdat_valid = 1'b1;
      wdat_data  = 16'hC300 + DW'(i);
      do @(negedge clk); while (!wdat_ready);
      @(posedge clk); #1;
    end
    wdat_valid = 1'b0;
  endtask

  task automatic buf_prog(logic [AW-1:0] a, int n, bit stall);
    exp_unlock("R8");
    exp_wr(a, 16'h0025, "R8");
    exp_wr(a, DW'(n - 1), "R8");
    for (int i = 0; i < n; i++) exp_wr(a + AW'(i), 16'hC300 + DW'(i), "R8");
    exp_wr(a + AW'(n - 1), 16'h0029, "R8");
    issue(3'd4, a, '0, CW'(n));
    feed(n, stall);
    wait_idle();
  endtask

  task automatic reject(logic [2:0] op, logic [CW-1:0] n);
    issue(op, 24'h000100, '0, n);
    @(negedge clk);
    chk(err, "R11", "err pulse", err, 1);
    chk(!busy, "R11", "busy on reject", busy, 0);
    @(negedge clk);
    chk(!err, "R11", "err single cycle", err, 0);
    repeat (3) @(negedge clk);
    chk(q_rd.size() == 0 && !busy, "R11", "quiet after reject", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !err, "R10", "reset busy/err", {busy, err}, 0);
    chk(!bus_we && !bus_re && !rd_valid, "R12", "reset strobes", {bus_we, bus_re, rd_valid}, 0);
    chk(!wdat_ready, "R9", "reset ready", wdat_ready, 0);

    // R1 R2 identifier read
    exp_unlock("R1");
    exp_wr(24'h555, 16'h0090, "R2");
    exp_rd(24'h000, "R2"); exp_rd(24'h001, "R2"); exp_rd(24'h00E, "R2"); exp_rd(24'h00F, "R2");
    issue(3'd0, 24'h123456, '0, '0);
    wait_idle();

    // R3 query read
    exp_wr(24'h055, 16'h0098, "R3");
    for (int i = 0; i < 4; i++) exp_rd(24'h010 + AW'(i), "R3");
    issue(3'd1, '0, '0, '0);
    wait_idle();

    // R4 return to read, then R5 program back to back
    exp_wr(24'h000, 16'h00F0, "R4");
    issue(3'd2, 24'h0ABCDE, '0, '0);
    exp_unlock("R5");
    exp_wr(24'h555, 16'h00A0, "R5");
    exp_wr(24'h012340, 16'hBEEF, "R5");
    issue(3'd3, 24'h012340, 16'hBEEF, '0);
    wait_idle();

    // R6 block erase
    exp_unlock("R6"); exp_wr(24'h555, 16'h0080, "R6"); exp_unlock("R6");
    exp_wr(24'h040000, 16'h0030, "R6");
    issue(3'd5, 24'h040000, '0, '0);
    wait_idle();

    // R7 chip erase, with a refused request while busy (R10)
    exp_unlock("R7"); exp_wr(24'h555, 16'h0080, "R7"); exp_unlock("R7");
    exp_wr(24'h555, 16'h0010, "R7");
    issue(3'd6, 24'h777777, '0, '0);
    req_valid = 1'b1; req_op = 3'd2;
    @(negedge clk);
    chk(!req_ack, "R10", "ack while busy", req_ack, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(!req_ack, "R10", "ack while busy 2", req_ack, 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_idle();

    // R8 buffer program: single word, stalled stream (R9), full buffer
    buf_prog(24'h002000, 1, 1'b0);
    buf_prog(24'h001000, 5, 1'b1);
    buf_prog(24'h00FFF8, BMAX, 1'b0);

    // R11 rejects
    reject(3'd4, '0);
    reject(3'd4, CW'(BMAX + 1));
    reject(3'd7, 8'd3);

    // R9 stream activity while idle is ignored
    @(posedge clk); #1;
    wdat_valid = 1'b1; wdat_data = 16'hDEAD;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!wdat_ready && !bus_we, "R9", "idle stream ignored", {wdat_ready, bus_we}, 0);
    end
    @(posedge clk); #1;
    wdat_valid = 1'b0;
    repeat (2) @(negedge clk);

    chk(q_rd.size() == 0 && r_dat.size() == 0, "R12", "scoreboard drained", q_rd.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule